// File: doc/BRIEF.md
# Video Sync Timing Generator

This block produces the horizontal, vertical, field and composite sync signals for standard-definition video. It supports both the 525-line/60 Hz and the 625-line/50 Hz line structures, each in interlaced or progressive scan. It runs on the 27 MHz sample clock of a multiplexed 4:2:2 stream, where every luma sample takes two clocks. One line therefore lasts 1716 clocks in 525 mode and 1728 clocks in 625 mode.

A sample counter and a line counter hold the position in the frame. As timing master the block runs these counters freely. As timing slave, a rising edge on the external horizontal sync restarts the sample counter and a rising edge on the external vertical sync restarts the line counter. A control bit can turn off the horizontal restart. The outputs are decoded from the counter values after the offsets are applied: a horizontal delay, a 3-bit fine phase trim, and a vertical delay that is used in slave mode only. Each of horizontal sync and vertical sync has its own polarity bit. One shared output pin carries either composite sync or field sync.

All configuration inputs are plain level signals, sampled on every clock. There is no streaming data interface and no handshake. Sync outputs are registered and follow the counters by one clock. The polarity bits and the pin select act on the outputs without delay.

Top module: `vsync_timing_gen`

## Requirements
- R1: While `rst_n` is low, both counters are held at zero. The registered syncs are inactive, so `hsync_o` equals `cfg_hs_invert`, `vsync_o` equals `cfg_vs_invert`, `fsync_o` is 0, and `csfs_o` with `cfg_pin_csync`=1 equals `cfg_hs_invert`.
- R2: In master mode the horizontal sync repeats every H_TOTAL_525 clocks (default 1716) when `cfg_std625`=0, and every H_TOTAL_625 clocks (default 1728) when `cfg_std625`=1.
- R3: The active phase of horizontal sync lasts HS_WIDTH clocks (default 128).
- R4: Horizontal sync becomes active when the sample counter equals (`cfg_hdelay` + `cfg_hphase` − 3) modulo the line length. A phase code of 0 places sync 3 clocks early and a code of 7 places it 4 clocks late. `cfg_hdelay` must be below the line length.
- R5: In slave mode with `cfg_selfrst_off`=0, a rising edge of `ext_hsync` restarts the line, whether it comes early or late. When the edge is sampled at clock edge c0 and D = `cfg_hdelay` + `cfg_hphase` − 3 ≥ 1, sync becomes active after edge c0+D+1. The next sync follows one full line after that.
- R6: In slave mode with `cfg_selfrst_off`=1, an edge on `ext_hsync` has no effect, and the sync period stays one line.
- R7: In master mode, `ext_hsync` has no effect on sync timing.
- R8: One frame holds V_TOTAL lines interlaced (default 525 or 625), split into a first field of (V_TOTAL+1)/2 lines and a second field with the remaining lines. Progressive frames hold V_TOTAL/2 lines (262 or 312). Vertical sync is active for the first VS_LINES lines of each field.
- R9: In interlaced mode, field sync is 0 in the first field and 1 in the second, so it changes at the start of each field. In progressive mode it stays 0.
- R10: In slave mode, a rising edge of `ext_vsync` (sampled at edge c0, together with `ext_hsync`) restarts the frame. Vertical sync then becomes active after edge c0 + `cfg_vdelay`·line + 1. In master mode `cfg_vdelay` is ignored, so vertical sync is active from the first clock after reset.
- R11: `cfg_hs_invert` inverts only `hsync_o`, and `cfg_vs_invert` inverts only `vsync_o`, each taking effect at once.
- R12: With `cfg_pin_csync`=1, `csfs_o` carries composite sync (horizontal OR vertical active) using the horizontal polarity. With `cfg_pin_csync`=0, it carries field sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_std625 | input | 1 | 0: 525-line mode, 1: 625-line mode |
| cfg_progressive | input | 1 | 1: non-interlaced scan |
| cfg_slave | input | 1 | 1: lock to external syncs |
| cfg_selfrst_off | input | 1 | 1: ignore external horizontal restart |
| cfg_hs_invert | input | 1 | 1: horizontal sync is active low |
| cfg_vs_invert | input | 1 | 1: vertical sync is active low |
| cfg_hphase | input | 3 | Fine phase trim, code − 3 clocks |
| cfg_hdelay | input | 11 | Horizontal delay in clocks |
| cfg_vdelay | input | 10 | Vertical delay in lines (slave only) |
| cfg_pin_csync | input | 1 | Shared pin select: 1 composite, 0 field |
| ext_hsync | input | 1 | External horizontal sync, active high |
| ext_vsync | input | 1 | External vertical sync, active high |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| fsync_o | output | 1 | Field sync |
| csfs_o | output | 1 | Composite sync or field sync |

## Verification
The checker runs on every cycle and checks four things:
- the sample counter stays within the current line length;
- in master mode, or with the restart disabled, the counter advances by exactly one;
- a qualified external edge always zeroes the counter;
- in master mode no horizontal pulse is longer than its width, and field sync stays at 0 in progressive scan.

Some properties need whole lines or whole frames to show, so only the bench scenarios cover them:
- the offset from an early or late external edge to the realigned pulse;
- the field lengths and the field-sync toggling across a frame;
- the vertical delay measured in lines;
- the composite and field content of the shared pin.

// File: rtl/vstg_pkg.sv
package vstg_pkg;
  // Decoded sync set, active-high, before polarity is applied
  typedef struct packed {
    logic hs;
    logic vs;
    logic fs;
    logic cs;
  } sync_t;
endpackage

// File: rtl/vstg_hcount.sv
module vstg_hcount #(
  parameter int H_A = 1716,
  parameter int H_B = 1728,
  parameter int HW  = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_b,
  input  logic          slave,
  input  logic          selfrst_off,
  input  logic          ext_hs,
  output logic [HW-1:0] hcnt,
  output logic          line_adv
);
  logic          ext_d;
  logic          restart;
  logic          at_end;
  logic [HW-1:0] last;

  assign last     = sel_b ? HW'(H_B - 1) : HW'(H_A - 1);
  assign at_end   = (hcnt >= last);
  assign restart  = slave & ~selfrst_off & ext_hs & ~ext_d;
  assign line_adv = restart | at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt  <= '0;
      ext_d <= 1'b0;
    end else begin
      ext_d <= ext_hs;
      if (restart || at_end) hcnt <= '0;
      else                   hcnt <= hcnt + 1'b1;
    end
  end
endmodule

// File: rtl/vstg_vcount.sv
module vstg_vcount #(
  parameter int V_A = 525,
  parameter int V_B = 625,
  parameter int VW  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_b,
  input  logic          prog,
  input  logic          slave,
  input  logic          ext_vs,
  input  logic          line_adv,
  output logic [VW-1:0] vcnt
);
  logic          ext_d;
  logic          restart;
  logic [VW-1:0] last;

  always_comb begin
    case ({sel_b, prog})
      2'b00:   last = VW'(V_A - 1);
      2'b01:   last = VW'(V_A / 2 - 1);
      2'b10:   last = VW'(V_B - 1);
      default: last = VW'(V_B / 2 - 1);
    endcase
  end

  assign restart = slave & ext_vs & ~ext_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vcnt  <= '0;
      ext_d <= 1'b0;
    end else begin
      ext_d <= ext_vs;
      if (restart)       vcnt <= '0;
      else if (line_adv) vcnt <= (vcnt >= last) ? '0 : vcnt + 1'b1;
    end
  end
endmodule

// File: rtl/vstg_decode.sv
module vstg_decode
  import vstg_pkg::*;
#(
  parameter int H_A  = 1716,
  parameter int H_B  = 1728,
  parameter int V_A  = 525,
  parameter int V_B  = 625,
  parameter int HSW  = 128,
  parameter int VSL  = 3,
  parameter int HW   = 11,
  parameter int VW   = 10,
  parameter int HDW  = 11,
  parameter int VDW  = 10
) (
  input  logic [HW-1:0]  hcnt,
  input  logic [VW-1:0]  vcnt,
  input  logic           sel_b,
  input  logic           prog,
  input  logic           slave,
  input  logic [2:0]     hphase,
  input  logic [HDW-1:0] hdelay,
  input  logic [VDW-1:0] vdelay,
  output sync_t          raw
);
  localparam int TW = ((HW > HDW) ? HW : HDW) + 2;
  localparam int QW = ((VW > VDW) ? VW : VDW) + 1;

  logic [TW-1:0] len, pos;
  logic [QW-1:0] full, nlin, f1, vd, q;

  always_comb begin
    // horizontal position relative to the delayed, trimmed sync start
    len = sel_b ? TW'(H_B) : TW'(H_A);
    pos = TW'(hcnt) + (len << 1) + TW'(3) - TW'(hdelay) - TW'(hphase);
    if (pos >= (len << 1)) pos = pos - (len << 1);
    if (pos >= len)        pos = pos - len;
    raw.hs = (pos < TW'(HSW));

    // vertical position relative to the (slave-only) delayed frame start
    full = sel_b ? QW'(V_B) : QW'(V_A);
    nlin = prog ? (full >> 1) : full;
    f1   = (full + QW'(1)) >> 1;
    vd   = slave ? QW'(vdelay) : '0;
    q    = QW'(vcnt) + nlin - vd;
    if (q >= nlin) q = q - nlin;
    raw.vs = (q < QW'(VSL)) | (~prog & (q >= f1) & (q < f1 + QW'(VSL)));
    raw.fs = ~prog & (q >= f1);
    raw.cs = raw.hs | raw.vs;
  end
endmodule

// File: rtl/vsync_timing_gen.sv
module vsync_timing_gen
  import vstg_pkg::*;
#(
  parameter int H_TOTAL_525 = 1716,
  parameter int H_TOTAL_625 = 1728,
  parameter int V_TOTAL_525 = 525,
  parameter int V_TOTAL_625 = 625,
  parameter int HS_WIDTH    = 128,
  parameter int VS_LINES    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_std625,
  input  logic        cfg_progressive,
  input  logic        cfg_slave,
  input  logic        cfg_selfrst_off,
  input  logic        cfg_hs_invert,
  input  logic        cfg_vs_invert,
  input  logic [2:0]  cfg_hphase,
  input  logic [10:0] cfg_hdelay,
  input  logic [9:0]  cfg_vdelay,
  input  logic        cfg_pin_csync,
  input  logic        ext_hsync,
  input  logic        ext_vsync,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        fsync_o,
  output logic        csfs_o
);
  localparam int HMAX = (H_TOTAL_625 > H_TOTAL_525) ? H_TOTAL_625 : H_TOTAL_525;
  localparam int VMAX = (V_TOTAL_625 > V_TOTAL_525) ? V_TOTAL_625 : V_TOTAL_525;
  localparam int HW   = $clog2(HMAX);
  localparam int VW   = $clog2(VMAX);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          line_adv;
  sync_t         raw, sync_q;

  vstg_hcount #(.H_A(H_TOTAL_525), .H_B(H_TOTAL_625), .HW(HW)) u_h (
    .clk(clk), .rst_n(rst_n), .sel_b(cfg_std625), .slave(cfg_slave),
    .selfrst_off(cfg_selfrst_off), .ext_hs(ext_hsync),
    .hcnt(hcnt), .line_adv(line_adv)
  );

  vstg_vcount #(.V_A(V_TOTAL_525), .V_B(V_TOTAL_625), .VW(VW)) u_v (
    .clk(clk), .rst_n(rst_n), .sel_b(cfg_std625), .prog(cfg_progressive),
    .slave(cfg_slave), .ext_vs(ext_vsync), .line_adv(line_adv), .vcnt(vcnt)
  );

  vstg_decode #(
    .H_A(H_TOTAL_525), .H_B(H_TOTAL_625), .V_A(V_TOTAL_525), .V_B(V_TOTAL_625),
    .HSW(HS_WIDTH), .VSL(VS_LINES), .HW(HW), .VW(VW), .HDW(11), .VDW(10)
  ) u_d (
    .hcnt(hcnt), .vcnt(vcnt), .sel_b(cfg_std625), .prog(cfg_progressive),
    .slave(cfg_slave), .hphase(cfg_hphase), .hdelay(cfg_hdelay),
    .vdelay(cfg_vdelay), .raw(raw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= raw;
  end

  assign hsync_o = sync_q.hs ^ cfg_hs_invert;
  assign vsync_o = sync_q.vs ^ cfg_vs_invert;
  assign fsync_o = sync_q.fs;
  assign csfs_o  = cfg_pin_csync ? (sync_q.cs ^ cfg_hs_invert) : sync_q.fs;
endmodule

// File: rtl/vstg_checker.sv
module vstg_checker #(
  parameter int H_TOTAL_525 = 1716,
  parameter int H_TOTAL_625 = 1728,
  parameter int HS_WIDTH    = 128,
  parameter int HW          = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_std625,
  input logic          cfg_progressive,
  input logic          cfg_slave,
  input logic          cfg_selfrst_off,
  input logic          cfg_hs_invert,
  input logic [2:0]    cfg_hphase,
  input logic [10:0]   cfg_hdelay,
  input logic          ext_hsync,
  input logic [HW-1:0] hcnt,
  input logic          hsync_o,
  input logic          fsync_o
);
  logic          past_ok;
  logic          ext_d;
  logic [15:0]   run;
  logic [16:0]   cfg_d;
  logic [16:0]   cfg_now;
  logic [HW-1:0] line_last;

  assign line_last = cfg_std625 ? HW'(H_TOTAL_625 - 1) : HW'(H_TOTAL_525 - 1);
  assign cfg_now   = {cfg_slave, cfg_std625, cfg_hdelay, cfg_hphase, cfg_hs_invert};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      ext_d   <= 1'b0;
      run     <= '0;
      cfg_d   <= '0;
    end else begin
      past_ok <= 1'b1;
      ext_d   <= ext_hsync;
      cfg_d   <= cfg_now;
      if (cfg_now != cfg_d || cfg_slave) run <= '0;
      else if (hsync_o ^ cfg_hs_invert)  run <= (run == 16'hFFFF) ? run : run + 1'b1;
      else                               run <= '0;
    end
  end

  // R2: the sample counter never leaves the current line
  a_r2_hcnt_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |=> hcnt <= $past(line_last));

  // R2, R7: master counting advances by one inside a line
  a_r7_master_step: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !cfg_slave && hcnt < line_last) |=> hcnt == $past(hcnt) + 1'b1);

  // R5: a qualified external edge zeroes the counter
  a_r5_slave_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cfg_slave && !cfg_selfrst_off && ext_hsync && !ext_d) |=> hcnt == '0);

  // R6: with restart disabled the counter keeps stepping
  a_r6_restart_off: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cfg_selfrst_off && hcnt < line_last) |=> hcnt == $past(hcnt) + 1'b1);

  // R3: a master pulse is never wider than its width
  a_r3_hs_width: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !cfg_slave) |-> run <= 16'(HS_WIDTH));

  // R9: progressive scan holds field sync low
  a_r9_prog_fs_low: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cfg_progressive)) |-> !fsync_o);
endmodule

bind vsync_timing_gen vstg_checker #(
  .H_TOTAL_525(H_TOTAL_525), .H_TOTAL_625(H_TOTAL_625),
  .HS_WIDTH(HS_WIDTH), .HW(HW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_std625(cfg_std625),
  .cfg_progressive(cfg_progressive), .cfg_slave(cfg_slave),
  .cfg_selfrst_off(cfg_selfrst_off), .cfg_hs_invert(cfg_hs_invert),
  .cfg_hphase(cfg_hphase), .cfg_hdelay(cfg_hdelay), .ext_hsync(ext_hsync),
  .hcnt(hcnt), .hsync_o(hsync_o), .fsync_o(fsync_o)
);

// File: tb/sim_vsync_timing_gen.sv
module sim_vsync_timing_gen;
  localparam int HA = 100, HB = 108, VA = 21, VB = 25, HSW = 16, VSL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic std = 1'b0, prog = 1'b0, slave = 1'b0, soff = 1'b0;
  logic hinv = 1'b0, vinv = 1'b0, pin_cs = 1'b1;
  logic [2:0]  hph = 3'd3;
  logic [10:0] hdl = '0;
  logic [9:0]  vdl = '0;
  logic ehs = 1'b0, evs = 1'b0;
  logic hs_o, vs_o, fs_o, csfs;
  int cyc = 0, checks = 0, fails = 0;
  bit done = 1'b0;

  vsync_timing_gen #(
    .H_TOTAL_525(HA), .H_TOTAL_625(HB), .V_TOTAL_525(VA), .V_TOTAL_625(VB),
    .HS_WIDTH(HSW), .VS_LINES(VSL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_std625(std), .cfg_progressive(prog),
    .cfg_slave(slave), .cfg_selfrst_off(soff), .cfg_hs_invert(hinv),
    .cfg_vs_invert(vinv), .cfg_hphase(hph), .cfg_hdelay(hdl), .cfg_vdelay(vdl),
    .cfg_pin_csync(pin_cs), .ext_hsync(ehs), .ext_vsync(evs),
    .hsync_o(hs_o), .vsync_o(vs_o), .fsync_o(fs_o), .csfs_o(csfs)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lin(bit s);  return s ? HB : HA; endfunction
  function automatic int vtot(bit s); return s ? VB : VA; endfunction
  function automatic int fld1(bit s); return (vtot(s) + 1) / 2; endfunction
  function automatic bit hr(); return hs_o ^ hinv; endfunction
  function automatic bit vr(); return vs_o ^ vinv; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hs_rise(output int t);
    do @(negedge clk); while (hr());
    do @(negedge clk); while (!hr());
    t = cyc;
  endtask
  task automatic hs_fall(output int t);
    do @(negedge clk); while (hr());
    t = cyc;
  endtask
  task automatic vs_rise(output int t);
    do @(negedge clk); while (vr());
    do @(negedge clk); while (!vr());
    t = cyc;
  endtask
  task automatic vs_fall(output int t);
    do @(negedge clk); while (vr());
    t = cyc;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int r1, r2, f1, c0, t, v1, v2, v3, w1, d, k, mis;
    bit s1, s2, s3, oh, ov;
    void'($urandom(32'd20240611));

    // R1: reset state with both polarities inverted
    hinv = 1'b1; vinv = 1'b1; pin_cs = 1'b1; vdl = 10'd5;
    repeat (4) @(negedge clk);
    chk(hs_o == 1'b1, "R1 hsync in reset", hs_o, 1);
    chk(vs_o == 1'b1, "R1 vsync in reset", vs_o, 1);
    chk(fs_o == 1'b0, "R1 fsync in reset", fs_o, 0);
    chk(csfs == 1'b1, "R1 shared pin in reset", csfs, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: master ignores vdelay, so vertical sync is active straight away
    chk(vr() == 1'b1, "R10 master vdelay ignored", vr(), 1);
    hinv = 1'b0; vinv = 1'b0; vdl = '0;

    // R2, R3, R4: master line length and pulse width under random trims
    for (int i = 0; i < 10; i++) begin
      std = 1'($urandom_range(1, 0));
      hph = 3'($urandom_range(7, 0));
      hdl = 11'($urandom_range(lin(std) - 1, 0));
      hs_rise(t);
      hs_rise(r1); hs_fall(f1); hs_rise(r2);
      chk(f1 - r1 == HSW, "R3 hsync width", f1 - r1, HSW);
      chk(r2 - r1 == lin(std), "R2 line length", r2 - r1, lin(std));
    end

    // R7 (master) and R6 (slave, restart off): external edge has no effect
    for (int i = 0; i < 6; i++) begin
      slave = (i >= 3); soff = (i >= 3);
      std = 1'($urandom_range(1, 0));
      hdl = 11'($urandom_range(40, 0)); hph = 3'($urandom_range(7, 0));
      hs_rise(t);
      hs_rise(r1);
      k = $urandom_range(lin(std) - HSW - 8, 2);
      repeat (k) @(negedge clk);
      ehs = 1'b1; @(negedge clk); @(negedge clk); ehs = 1'b0;
      hs_rise(r2);
      if (i < 3) chk(r2 - r1 == lin(std), "R7 master ignores ext hsync", r2 - r1, lin(std));
      else       chk(r2 - r1 == lin(std), "R6 restart disabled", r2 - r1, lin(std));
    end

    // R5, R4: slave realignment by an early or late external edge
    slave = 1'b1; soff = 1'b0;
    for (int i = 0; i < 10; i++) begin
      std = 1'($urandom_range(1, 0));
      hph = 3'($urandom_range(7, 0));
      hdl = 11'($urandom_range(lin(std) - HSW - 12, 4));
      d = int'(hdl) + int'(hph) - 3;
      repeat ($urandom_range(lin(std) - 1, 1)) @(negedge clk);
      ehs = 1'b1;
      @(negedge clk); c0 = cyc;
      ehs = 1'b0;
      hs_rise(t);
      chk(t - c0 == d + 1, "R5 R4 realigned hsync offset", t - c0, d + 1);
      hs_rise(r2);
      chk(r2 - t == lin(std), "R5 line after realign", r2 - t, lin(std));
    end

    // R10: slave vertical delay in whole lines
    hdl = 11'd10; hph = 3'd3;
    for (int i = 0; i < 4; i++) begin
      std = i[0]; prog = i[1];
      vdl = 10'($urandom_range(5, 1));
      repeat (7) @(negedge clk);
      ehs = 1'b1; evs = 1'b1;
      @(negedge clk); c0 = cyc;
      ehs = 1'b0; evs = 1'b0;
      vs_rise(t);
      chk(t - c0 == int'(vdl) * lin(std) + 1, "R10 slave vdelay",
          t - c0, int'(vdl) * lin(std) + 1);
    end

    // R8, R9: frame structure in master mode
    slave = 1'b0; vdl = '0; hdl = '0; pin_cs = 1'b0;
    for (int i = 0; i < 4; i++) begin
      std = i[0]; prog = i[1];
      vs_rise(t);
      vs_rise(v1); s1 = fs_o;
      chk(csfs == fs_o, "R12 pin carries field sync", csfs, fs_o);
      vs_fall(w1);
      chk(w1 - v1 == VSL * lin(std), "R8 vsync width", w1 - v1, VSL * lin(std));
      vs_rise(v2); s2 = fs_o;
      vs_rise(v3); s3 = fs_o;
      if (prog) begin
        chk(v2 - v1 == (vtot(std) / 2) * lin(std), "R8 progressive frame",
            v2 - v1, (vtot(std) / 2) * lin(std));
        chk(!s1 && !s2 && !s3, "R9 progressive fsync low", s1 | s2 | s3, 0);
      end else begin
        k = (s1 == 1'b0) ? fld1(std) : vtot(std) - fld1(std);
        chk(v2 - v1 == k * lin(std), "R8 interlaced field", v2 - v1, k * lin(std));
        chk(v3 - v1 == vtot(std) * lin(std), "R8 interlaced frame",
            v3 - v1, vtot(std) * lin(std));
        chk(s2 != s1 && s3 == s1, "R9 fsync toggles per field", s2, !s1);
      end
    end

    // R12: composite on the shared pin; R11: polarity independence
    prog = 1'b0; std = 1'b0; pin_cs = 1'b1;
    hinv = 1'($urandom_range(1, 0)); vinv = 1'($urandom_range(1, 0));
    mis = 0;
    for (int i = 0; i < 3 * HA * VSL; i++) begin
      @(negedge clk);
      if (csfs != ((hr() | vr()) ^ hinv)) mis++;
    end
    chk(mis == 0, "R12 composite sync on pin", mis, 0);
    @(negedge clk);
    oh = hs_o; ov = vs_o;
    hinv = ~hinv; #1;
    chk(hs_o == !oh && vs_o == ov, "R11 hsync inversion alone", hs_o, !oh);
    oh = hs_o;
    vinv = ~vinv; #1;
    chk(vs_o == !ov && hs_o == oh, "R11 vsync inversion alone", vs_o, !ov);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule